// File: doc/BRIEF.md
# Local-bus to IDE PIO cycle engine

This block sits between a 32-bit synchronous host port and the 16-bit parallel data bus of an IDE drive. A host access to the drive's data register is 32 bits wide. The block turns it into two 16-bit drive cycles that run one after the other, with the lower halfword first. A host access to any other drive register is one 8-bit cycle with its own, slower timing. A 512-byte sector therefore crosses the host port as 128 such 32-bit accesses.

The strobe width and the full cycle length come from a built-in table. The table is indexed by the host clock setting (33 MHz or the default 50 MHz) and by a per-drive timing type. Each of the two drives has its own type, so a fast drive is not slowed to the pace of a slow one. The host raises a request. The block holds a wait signal high until the last drive cycle has finished its recovery time, then pulses ready for one clock.

Top module: `ide_pio_bridge`

## Requirements
- R1: A host access with `host_wide`=1 produces exactly two drive strobes, both at drive address 0. The lower halfword (`host_wdata[15:0]`) goes out on the first strobe and the upper halfword on the second.
- R2: On a wide read, `host_rdata[15:0]` holds the drive data sampled during the first strobe and `host_rdata[31:16]` holds the data sampled during the second. Ready is given only after the second strobe has ended.
- R3: A host access with `host_wide`=0 produces exactly one strobe at drive address `host_addr`. On a write, `ide_dout` is {8'h00, `host_wdata[7:0]`}. On a read, `host_rdata` is {24'h0, `ide_din[7:0]`}.
- R4: The strobe stays low for A clocks. With the 50 MHz setting, A is 9/7/5 for data cycles of types 0/1/2 and 15 for register cycles.
- R5: Each drive cycle lasts T = max(C, A+2) clocks, counted from the setup clock to the end of recovery. At 50 MHz, C is 30/20/12 for data cycles and 30/20/16 for register cycles of types 0/1/2, which gives T = 17 for a type-2 register cycle.
- R6: With `cfg_clk33`=1, A is 6/5/4 for data cycles and 10 for register cycles. C is 20/13/8 for data cycles and 20/13/11 for register cycles, and T follows the same rule as in R5.
- R7: The timing type comes from `cfg_type_d0` when `host_drv`=0 and from `cfg_type_d1` when `host_drv`=1. Type code 3 is treated as type 0.
- R8: A request is accepted only while `host_wait` is low. From the clock after acceptance, `host_wait` stays high for exactly N*T clocks, where N is 2 for wide accesses and 1 for register accesses. `host_rdy` is high for the single clock in which `host_wait` first returns low.
- R9: `ide_cs_n` is low and `ide_addr` and `ide_dout` are stable for at least one clock before each strobe falls. On a write, `ide_dout` is still held and `ide_doe` is still high for at least one clock after the strobe rises.
- R10: After reset, both strobes and `ide_cs_n` are high, and `ide_doe`, `host_wait` and `host_rdy` are low.
- R11: The read and write strobes are never low at the same time. `ide_doe` is high only during write accesses, never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk33 | input | 1 | 1 selects the 33 MHz timing set, 0 the 50 MHz set |
| cfg_type_d0 | input | 2 | Timing type of drive 0 |
| cfg_type_d1 | input | 2 | Timing type of drive 1 |
| host_req | input | 1 | Access request |
| host_drv | input | 1 | Drive whose timing type applies |
| host_wide | input | 1 | 1 = 32-bit data register access, 0 = 8-bit register access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Drive register address for 8-bit accesses |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with `host_rdy` |
| host_wait | output | 1 | Access in progress |
| host_rdy | output | 1 | One-clock completion pulse |
| ide_din | input | 16 | Data from the drive |
| ide_dout | output | 16 | Data to the drive |
| ide_doe | output | 1 | Drive-data output enable |
| ide_addr | output | 3 | Drive register address |
| ide_cs_n | output | 1 | Drive chip select, active low |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |

## Verification
The properties assume that the host changes the configuration inputs only while `host_wait` is low. They also assume that the drive keeps `ide_din` steady while a read strobe is low. The stimulus changes `cfg_clk33` and the drive types only between accesses, starting from an idle negative edge. The drive model loads new data on `ide_din` only at the falling edge of a read strobe. One directed case holds `host_req` high for the whole access, to show that a request is ignored while `host_wait` is high.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int CW     = 6;   // cycle counter width
    localparam int HW     = 16;  // drive bus width
    localparam int BW     = 32;  // host bus width
    localparam int NHALF  = BW / HW;
    localparam int AW     = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOV
    } cyc_state_e;

    typedef struct packed {
        logic [CW-1:0] act;  // strobe-low clocks
        logic [CW-1:0] per;  // whole cycle clocks
    } timing_t;

    typedef struct packed {
        logic          we;
        logic          wide;
        logic [AW-1:0] addr;
        logic [BW-1:0] wdata;
    } host_cmd_t;

    function automatic timing_t timing_lookup(input logic clk33,
                                              input logic wide,
                                              input logic [1:0] typ);
        logic [1:0]    t;
        logic [CW-1:0] a;
        logic [CW-1:0] c;
        timing_t       r;
        t = (typ == 2'd3) ? 2'd0 : typ;
        a = CW'(15);
        c = CW'(30);
        case ({clk33, wide, t})
            4'b0_1_00: begin a = CW'(9);  c = CW'(30); end
            4'b0_1_01: begin a = CW'(7);  c = CW'(20); end
            4'b0_1_10: begin a = CW'(5);  c = CW'(12); end
            4'b0_0_00: begin a = CW'(15); c = CW'(30); end
            4'b0_0_01: begin a = CW'(15); c = CW'(20); end
            4'b0_0_10: begin a = CW'(15); c = CW'(16); end
            4'b1_1_00: begin a = CW'(6);  c = CW'(20); end
            4'b1_1_01: begin a = CW'(5);  c = CW'(13); end
            4'b1_1_10: begin a = CW'(4);  c = CW'(8);  end
            4'b1_0_00: begin a = CW'(10); c = CW'(20); end
            4'b1_0_01: begin a = CW'(10); c = CW'(13); end
            4'b1_0_10: begin a = CW'(10); c = CW'(11); end
            default:   begin a = CW'(15); c = CW'(30); end
        endcase
        r.act = a;
        // one setup clock plus at least one hold clock around the strobe
        r.per = (c < a + CW'(2)) ? a + CW'(2) : c;
        return r;
    endfunction

endpackage

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
    import ide_pio_pkg::*;
(
    input  logic       clk33,
    input  logic       wide,
    input  logic [1:0] typ,
    output timing_t    tm
);
    assign tm = timing_lookup(clk33, wide, typ);
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
    import ide_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wide,
    input  timing_t    tm,
    output cyc_state_e st,
    output logic       half,
    output logic       cap,
    output logic       done
);
    logic [CW-1:0] cnt;
    logic          more;

    assign more = wide && !half;
    assign cap  = (st == ST_ACTIVE) && (cnt == '0);
    assign done = (st == ST_RECOV) && (cnt == '0) && !more;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            half <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_SETUP;
                        half <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    st  <= ST_ACTIVE;
                    cnt <= tm.act - CW'(1);
                end
                ST_ACTIVE: begin
                    if (cnt == '0) begin
                        st  <= ST_RECOV;
                        cnt <= tm.per - tm.act - CW'(2);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_RECOV: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CW'(1);
                    end else if (more) begin
                        st   <= ST_SETUP;
                        half <= 1'b1;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ide_word_pack.sv
module ide_word_pack
    import ide_pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic          half,
    input  logic          wide,
    input  logic [HW-1:0] din,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output logic [HW-1:0] dout
);
    logic [HW-1:0] part [NHALF];

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                part[g] <= '0;
            end else if (cap) begin
                if (wide && (half == 1'(g))) begin
                    part[g] <= din;
                end else if (!wide) begin
                    part[g] <= (g == 0) ? {8'h00, din[7:0]} : '0;
                end
            end
        end
        assign rdata[g*HW +: HW] = part[g];
    end

    always_comb begin
        if (!wide)     dout = {8'h00, wdata[7:0]};
        else if (half) dout = wdata[BW-1:HW];
        else           dout = wdata[HW-1:0];
    end
endmodule

// File: rtl/ide_pio_bridge.sv
module ide_pio_bridge
    import ide_pio_pkg::*;
#(
    parameter logic [2:0] DATA_REG = 3'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_clk33,
    input  logic [1:0]  cfg_type_d0,
    input  logic [1:0]  cfg_type_d1,
    input  logic        host_req,
    input  logic        host_drv,
    input  logic        host_wide,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_wait,
    output logic        host_rdy,
    input  logic [15:0] ide_din,
    output logic [15:0] ide_dout,
    output logic        ide_doe,
    output logic [2:0]  ide_addr,
    output logic        ide_cs_n,
    output logic        ide_dior_n,
    output logic        ide_diow_n
);
    cyc_state_e st;
    logic       half, cap, done, accept;
    timing_t    tm_new, tm_q;
    host_cmd_t  cmd_q;
    logic [1:0] typ_sel;

    assign typ_sel = host_drv ? cfg_type_d1 : cfg_type_d0;
    assign accept  = host_req && (st == ST_IDLE);

    ide_timing_sel u_tsel (
        .clk33 (cfg_clk33),
        .wide  (host_wide),
        .typ   (typ_sel),
        .tm    (tm_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            tm_q     <= '0;
            host_rdy <= 1'b0;
        end else begin
            host_rdy <= done;
            if (accept) begin
                cmd_q.we    <= host_we;
                cmd_q.wide  <= host_wide;
                cmd_q.addr  <= host_addr;
                cmd_q.wdata <= host_wdata;
                tm_q        <= tm_new;
            end
        end
    end

    ide_cycle_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .wide  (cmd_q.wide),
        .tm    (tm_q),
        .st    (st),
        .half  (half),
        .cap   (cap),
        .done  (done)
    );

    ide_word_pack u_pack (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap && !cmd_q.we),
        .half  (half),
        .wide  (cmd_q.wide),
        .din   (ide_din),
        .wdata (cmd_q.wdata),
        .rdata (host_rdata),
        .dout  (ide_dout)
    );

    assign host_wait  = (st != ST_IDLE);
    assign ide_cs_n   = (st == ST_IDLE);
    assign ide_addr   = cmd_q.wide ? DATA_REG : cmd_q.addr;
    assign ide_dior_n = !((st == ST_ACTIVE) && !cmd_q.we);
    assign ide_diow_n = !((st == ST_ACTIVE) && cmd_q.we);
    assign ide_doe    = (st != ST_IDLE) && cmd_q.we;
endmodule

// File: rtl/ide_pio_bridge_chk.sv
module ide_pio_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_wait,
    input logic        host_rdy,
    input logic [15:0] ide_dout,
    input logic        ide_doe,
    input logic [2:0]  ide_addr,
    input logic        ide_cs_n,
    input logic        ide_dior_n,
    input logic        ide_diow_n
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ide_dior_n && !ide_diow_n));

    // R11
    doe_read_chk: assert property (@(posedge clk) disable iff (rst)
        ide_doe |-> ide_dior_n);

    // R9
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!ide_dior_n || !ide_diow_n) |-> !ide_cs_n);

    // R9
    setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ide_dior_n) || $fell(ide_diow_n)) |->
            ($past(!ide_cs_n) && $stable(ide_addr) && $stable(ide_dout)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ide_diow_n) |-> ($stable(ide_dout) && ide_doe));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_wait) |=> host_wait);

    // R8
    rdy_chk: assert property (@(posedge clk) disable iff (rst)
        host_rdy |-> (!host_wait && $past(host_wait)));
endmodule

bind ide_pio_bridge ide_pio_bridge_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_wait  (host_wait),
    .host_rdy   (host_rdy),
    .ide_dout   (ide_dout),
    .ide_doe    (ide_doe),
    .ide_addr   (ide_addr),
    .ide_cs_n   (ide_cs_n),
    .ide_dior_n (ide_dior_n),
    .ide_diow_n (ide_diow_n)
);

// File: tb/ide_pio_bridge_tb_top.sv
module ide_pio_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_clk33 = 1'b0;
    logic [1:0]  cfg_type_d0 = 2'd0;
    logic [1:0]  cfg_type_d1 = 2'd0;
    logic        host_req = 1'b0;
    logic        host_drv = 1'b0;
    logic        host_wide = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait, host_rdy;
    logic [15:0] ide_din = '0;
    logic [15:0] ide_dout;
    logic        ide_doe, ide_cs_n, ide_dior_n, ide_diow_n;
    logic [2:0]  ide_addr;

    int checks = 0;
    int errors = 0;
    bit done_all = 1'b0;

    always #10 clk = ~clk;

    ide_pio_bridge dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int act_e(bit c33, bit wide, int typ);
        int t = (typ == 3) ? 0 : typ;
        if (!wide) return c33 ? 10 : 15;
        if (c33) return (t == 0) ? 6 : (t == 1) ? 5 : 4;
        return (t == 0) ? 9 : (t == 1) ? 7 : 5;
    endfunction

    function automatic int per_e(bit c33, bit wide, int typ);
        int t = (typ == 3) ? 0 : typ;
        int c;
        if (wide) c = c33 ? ((t == 0) ? 20 : (t == 1) ? 13 : 8)
                          : ((t == 0) ? 30 : (t == 1) ? 20 : 12);
        else      c = c33 ? ((t == 0) ? 20 : (t == 1) ? 13 : 11)
                          : ((t == 0) ? 30 : (t == 1) ? 20 : 16);
        return (c < act_e(c33, wide, typ) + 2) ? act_e(c33, wide, typ) + 2 : c;
    endfunction

    // Starts at a negedge with the bridge idle.
    task automatic xfer(input bit drv, input bit wide, input bit we,
                        input logic [2:0] a, input logic [31:0] wd,
                        input bit hold_req, input string rt);
        logic [15:0] words [2];
        logic [15:0] gotw [2];
        int   typ, n, wcnt, lcnt, nst, guard;
        bit   seen, p_r, p_w, p_cs;
        logic [2:0]  p_addr;
        logic [15:0] p_dout;
        logic [31:0] exp_rd;
        typ = drv ? int'(cfg_type_d1) : int'(cfg_type_d0);
        n = wide ? 2 : 1;
        words[0] = 16'($urandom); words[1] = 16'($urandom);
        gotw[0] = '0; gotw[1] = '0;
        wcnt = 0; lcnt = 0; nst = 0; seen = 0; guard = 0;
        p_r = 1; p_w = 1; p_cs = 1; p_addr = ide_addr; p_dout = ide_dout;
        host_drv = drv; host_wide = wide; host_we = we;
        host_addr = a; host_wdata = wd; host_req = 1'b1;
        @(posedge clk); @(negedge clk);
        if (!hold_req) host_req = 1'b0;
        while (!seen && guard < 200) begin
            guard++;
            if (host_rdy) begin
                seen = 1;
                chk("R8 wait low at ready", 32'(host_wait), 32'd0);
            end else begin
                if (host_wait) wcnt++;
                if (!ide_dior_n || !ide_diow_n) lcnt++;
                if ((!ide_dior_n && p_r) || (!ide_diow_n && p_w)) begin
                    chk("R9 setup", {p_cs, (p_addr == ide_addr), (p_dout == ide_dout)},
                        {1'b0, 1'b1, 1'b1});
                    chk(wide ? "R1 strobe address" : "R3 strobe address",
                        32'(ide_addr), wide ? 32'd0 : 32'(a));
                    chk("R11 doe only on write", 32'(ide_doe), 32'(we));
                    if (nst < 2) begin
                        if (!ide_dior_n) ide_din = words[nst];
                        else gotw[nst] = ide_dout;
                    end
                    nst++;
                end
                if (we && ide_diow_n && !p_w)
                    chk("R9 write hold", {15'd0, ide_doe, ide_dout}, {15'd0, 1'b1, p_dout});
            end
            p_r = ide_dior_n; p_w = ide_diow_n; p_cs = ide_cs_n;
            p_addr = ide_addr; p_dout = ide_dout;
            if (!seen) @(negedge clk);
        end
        chk("R8 ready seen", 32'(seen), 32'd1);
        chk({rt, " cycle length"}, 32'(wcnt), 32'(n * per_e(cfg_clk33, wide, typ)));
        chk(cfg_clk33 ? "R6 strobe width" : "R4 strobe width",
            32'(lcnt), 32'(n * act_e(cfg_clk33, wide, typ)));
        chk(wide ? "R1 strobe count" : "R3 strobe count", 32'(nst), 32'(n));
        if (!we) begin
            exp_rd = wide ? {words[1], words[0]} : {24'd0, words[0][7:0]};
            chk(wide ? "R2 read assembly" : "R3 byte read", host_rdata, exp_rd);
        end else if (wide) begin
            chk("R1 write halves", {gotw[1], gotw[0]}, wd);
        end else begin
            chk("R3 byte write", 32'(gotw[0]), {24'd0, wd[7:0]});
        end
        if (hold_req) begin
            host_req = 1'b0;
            @(negedge clk);
            chk("R8 held request not re-accepted early", 32'(host_wait), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            errors++;
            $display("FAIL R8 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs",
            {ide_dior_n, ide_diow_n, ide_cs_n, ide_doe, host_wait, host_rdy},
            {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after reset idle", {host_wait, ide_cs_n}, {1'b0, 1'b1});

        // directed sweep over clock set, width, type (including code 3)
        for (int c = 0; c < 2; c++) begin
            for (int t = 0; t < 4; t++) begin
                for (int w = 0; w < 2; w++) begin
                    cfg_clk33 = c[0];
                    cfg_type_d0 = t[1:0];
                    xfer(1'b0, w[0], 1'b0, 3'd7, $urandom, 1'b0, c ? "R6" : "R5");
                    xfer(1'b0, w[0], 1'b1, 3'd5, $urandom, 1'b0, c ? "R6" : "R5");
                end
            end
        end

        // R7: per-drive timing types
        cfg_clk33 = 1'b0;
        cfg_type_d0 = 2'd2;
        cfg_type_d1 = 2'd0;
        xfer(1'b1, 1'b1, 1'b0, 3'd0, 32'h0, 1'b0, "R7");
        xfer(1'b0, 1'b1, 1'b1, 3'd0, 32'hDEAD_BEEF, 1'b0, "R7");
        cfg_type_d1 = 2'd3;
        xfer(1'b1, 1'b0, 1'b1, 3'd2, 32'h0000_00A5, 1'b0, "R7");

        // R8: request held high for the whole access
        xfer(1'b0, 1'b1, 1'b0, 3'd0, 32'h0, 1'b1, "R8");
        xfer(1'b1, 1'b0, 1'b1, 3'd6, 32'h1234_5678, 1'b1, "R8");

        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            cfg_clk33 = 1'($urandom);
            cfg_type_d0 = 2'($urandom);
            cfg_type_d1 = 2'($urandom);
            xfer(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
                 $urandom, 1'($urandom_range(0, 3) == 0), cfg_clk33 ? "R6" : "R5");
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        done_all = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule